// File: doc/BRIEF.md
# Process Timeout Scanner

The scanner sits beside a process scheduler and retires waits that have run out of time. It takes a 60 Hz tick pulse and divides it down so that one scan runs for every three ticks. At the start of each scan a 16-bit time counter advances by one. The scanner then walks a table of process descriptors held in a local word-addressed RAM. Each descriptor whose stored deadline is nonzero and matches the new time is expired:

- its deadline word is cleared;
- its waiting flag is dropped;
- it is offered on a requeue request port. The consumer of that port moves the process to the ready queue without being told which queue it currently sits on.

Deadlines are absolute points on the wrapping time counter, and the value zero means the process waits forever. A combinational helper turns a relative wait into such a deadline against the current time. The scheduler reaches the descriptor RAM through a write port that is honoured only while no scan runs, and through an asynchronous read port. A tick that arrives while a scan is in progress is remembered and serviced once the scan has finished.

Top module: `process_timeout_scanner`

## Requirements
- R1: After reset, `cur_time` is 0 and `busy`, `scan_done` and `rq_req` are all low.
- R2: Ticks are counted only while idle. The third counted tick after reset starts a scan, and so does every third one after that. The start of a scan raises `busy` and increments `cur_time` by one in the same cycle; no other event changes `cur_time`.
- R3: At the start of a scan the descriptor count is read from RAM word 1. A count above the table capacity (48 with default parameters) is limited to that capacity. A count of 0 produces a scan with no requests.
- R4: Descriptor i occupies RAM words 64+4i to 64+4i+3, and its deadline is word 64+4i+3. A descriptor is expired only if that word is nonzero and equal to `cur_time`.
- R5: Expiry writes the deadline word to 0 and clears bit 1 of the flags word (64+4i+1). All other flag bits are left unchanged, and non-expired descriptors are left untouched.
- R6: For each expiry, `rq_req` rises with `rq_handle` = 64+4i. Both are held until `rq_done` is seen high at a clock edge, and the scan does not move on in the meantime. Requests are issued in ascending descriptor order.
- R7: After the last descriptor, `scan_done` is high for exactly one cycle, and `busy` is low in the following cycle.
- R8: A tick that arrives while `busy` is high is latched and counted after the scan. At most one such tick is kept.
- R9: `deadline` is 0 when `wait_in` is 0. Otherwise it is `cur_time` + `wait_in` modulo 2^16, with a result of 0 replaced by 1.
- R10: `wr_en` writes `wr_data` to `wr_addr` only while `busy` is low, and is ignored during a scan. `rd_data` always shows the RAM word at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 60 Hz tick pulse |
| wr_en | input | 1 | Descriptor RAM write strobe |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 16 | Read data (combinational) |
| wait_in | input | 16 | Relative wait for the deadline helper |
| deadline | output | 16 | Absolute deadline computed from `wait_in` |
| cur_time | output | 16 | Current time in scan periods |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| rq_req | output | 1 | Requeue request for an expired descriptor |
| rq_handle | output | 8 | Word address of the expired descriptor |
| rq_done | input | 1 | Requeue completed |

## Verification
The hardest situation to reach is a tick arriving mid-scan: a scan lasts only a few cycles, so a tick seldom lands inside one. The bench withholds `rq_done` to freeze a scan on a request. While it is frozen, the bench issues two ticks and also attempts a RAM write. It then checks the divider phase after the scan, which shows that exactly one of the two ticks was kept. A second awkward case is a count word far beyond the table. The bench plants a matching deadline at the word a wrapped index would reach and confirms that no request for it appears. Deadline wrap to 1 is reached directly by driving a large relative wait.

// File: rtl/process_timeout_scanner.sv
`timescale 1ns/1ps
module process_timeout_scanner #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int BASE     = 64,
  parameter int STRIDE   = 4,
  parameter int CNT_ADDR = 1,
  parameter int FL_OFS   = 1,
  parameter int TO_OFS   = 3,
  parameter int WAIT_BIT = 1,
  parameter int DIV_N    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] wait_in,
  output logic [DATA_W-1:0] deadline,
  output logic [DATA_W-1:0] cur_time,
  output logic              busy,
  output logic              scan_done,
  output logic              rq_req,
  output logic [ADDR_W-1:0] rq_handle,
  input  logic              rq_done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CAP   = (DEPTH - BASE) / STRIDE;
  localparam int IW    = $clog2(CAP + 1);
  localparam int DW    = (DIV_N > 1) ? $clog2(DIV_N) : 1;

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_CHK, S_CLRT, S_CLRF, S_REQ, S_FIN} st_t;

  st_t st;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IW-1:0]     idx, limit;
  logic [DW-1:0]     div;
  logic              pend;
  logic [DATA_W-1:0] now;

  logic [ADDR_W-1:0] base, to_addr, fl_addr;
  logic [DATA_W-1:0] to_word, fl_word, cnt_word, sum;
  logic [IW-1:0]     lim_c;
  logic              hit, last;
  logic              mw_en;
  logic [ADDR_W-1:0] mw_addr;
  logic [DATA_W-1:0] mw_data;

  assign base     = ADDR_W'(BASE) + ADDR_W'(idx) * ADDR_W'(STRIDE);
  assign to_addr  = base + ADDR_W'(TO_OFS);
  assign fl_addr  = base + ADDR_W'(FL_OFS);
  assign to_word  = mem[to_addr];
  assign fl_word  = mem[fl_addr];
  assign cnt_word = mem[CNT_ADDR];
  assign lim_c    = (cnt_word > DATA_W'(CAP)) ? IW'(CAP) : IW'(cnt_word);
  assign hit      = (to_word != '0) && (to_word == now);
  assign last     = (idx == limit - 1'b1);

  assign sum      = now + wait_in;
  assign deadline = (wait_in == '0) ? '0 : ((sum == '0) ? DATA_W'(1) : sum);

  assign rd_data   = mem[rd_addr];
  assign cur_time  = now;
  assign busy      = (st != S_IDLE);
  assign scan_done = (st == S_FIN);
  assign rq_req    = (st == S_REQ);
  assign rq_handle = base;

  always_comb begin
    mw_en   = 1'b0;
    mw_addr = wr_addr;
    mw_data = wr_data;
    if (st == S_CLRT) begin
      mw_en   = 1'b1;
      mw_addr = to_addr;
      mw_data = '0;
    end else if (st == S_CLRF) begin
      mw_en   = 1'b1;
      mw_addr = fl_addr;
      mw_data = fl_word & ~(DATA_W'(1) << WAIT_BIT);
    end else if (st == S_IDLE) begin
      mw_en = wr_en;
    end
  end

  always_ff @(posedge clk)
    if (mw_en) mem[mw_addr] <= mw_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      limit <= '0;
      div   <= DW'(DIV_N - 1);
      pend  <= 1'b0;
      now   <= '0;
    end else begin
      if (st != S_IDLE && tick) pend <= 1'b1;
      case (st)
        S_IDLE: if (tick || pend) begin
          pend <= pend & tick;
          if (div == '0) begin
            div <= DW'(DIV_N - 1);
            now <= now + 1'b1;
            st  <= S_CNT;
          end else begin
            div <= div - 1'b1;
          end
        end
        S_CNT: begin
          idx   <= '0;
          limit <= lim_c;
          st    <= (lim_c == '0) ? S_FIN : S_CHK;
        end
        S_CHK: begin
          if (hit)       st  <= S_CLRT;
          else if (last) st  <= S_FIN;
          else           idx <= idx + 1'b1;
        end
        S_CLRT: st <= S_CLRF;
        S_CLRF: st <= S_REQ;
        S_REQ: if (rq_done) begin
          if (last) st <= S_FIN;
          else begin
            idx <= idx + 1'b1;
            st  <= S_CHK;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/process_timeout_scanner_chk.sv
`timescale 1ns/1ps
module process_timeout_scanner_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              scan_done,
  input logic              rq_req,
  input logic              rq_done,
  input logic [ADDR_W-1:0] rq_handle,
  input logic [DATA_W-1:0] cur_time,
  input logic [DATA_W-1:0] wait_in,
  input logic [DATA_W-1:0] deadline
);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_req && !rq_done) |=> (rq_req && $stable(rq_handle)));

  p_req_in_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rq_req |-> busy);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> (!scan_done && !busy));

  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_time != $past(cur_time)) |-> (cur_time == $past(cur_time) + 1'b1));

  p_time_starts_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_time != $past(cur_time)) |-> busy);

  p_forever_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_in == '0) |-> (deadline == '0));

  p_nonzero_deadline_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_in != '0) |-> (deadline != '0));
endmodule

bind process_timeout_scanner process_timeout_scanner_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .scan_done(scan_done), .rq_req(rq_req),
  .rq_done(rq_done), .rq_handle(rq_handle), .cur_time(cur_time),
  .wait_in(wait_in), .deadline(deadline));

// File: tb/sim_process_timeout_scanner.sv
`timescale 1ns/1ps
module sim_process_timeout_scanner;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rq_done = 0;
  logic [7:0]  wr_addr = 0, rd_addr = 0, rq_handle;
  logic [15:0] wr_data = 0, wait_in = 0, rd_data, deadline, cur_time;
  logic busy, scan_done, rq_req;
  int checks = 0, fails = 0;
  bit auto_ack = 1;
  int got[$];

  always #10 clk = ~clk;

  process_timeout_scanner u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wait_in(wait_in),
    .deadline(deadline), .cur_time(cur_time), .busy(busy), .scan_done(scan_done),
    .rq_req(rq_req), .rq_handle(rq_handle), .rq_done(rq_done));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dl_model(input int now, input int w);
    int s;
    if (w == 0) return 0;
    s = (now + w) % 65536;
    return (s == 0) ? 1 : s;
  endfunction

  always @(negedge clk) begin
    rq_done = auto_ack && rq_req;
    if (rq_req && rq_done) got.push_back(int'(rq_handle));
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) chk("R9 per-clock deadline", deadline, dl_model(cur_time, wait_in));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 8'(a); wr_data = 16'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 8'(a); #1 d = int'(rd_data);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!scan_done && n < 3000) begin @(negedge clk); n++; end
    chk("R7 scan_done seen", scan_done, 1);
    @(negedge clk);
    chk("R7 scan_done one cycle", scan_done, 0);
    chk("R7 busy low after done", busy, 0);
  endtask

  task automatic chk_got(input string tag, input int exp[$]);
    chk({tag, " request count"}, got.size(), exp.size());
    foreach (exp[k]) if (k < got.size()) chk({tag, " handle order"}, got[k], exp[k]);
    got.delete();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cur_time", cur_time, 0);
    chk("R1 busy", busy, 0);
    chk("R1 scan_done", scan_done, 0);
    chk("R1 rq_req", rq_req, 0);

    for (int i = 0; i < 48; i++) begin
      wr(64 + 4*i + 3, 0);
      wr(64 + 4*i + 1, 0);
    end
    wr(3, 0);
    wr(1, 3);
    wr(67, 1); wr(65, 16'hF3);
    wr(71, 0); wr(69, 16'h2);
    wr(75, 1); wr(73, 16'h2);
    wr(100, 16'hABCD);

    pulse_tick(); pulse_tick();
    chk("R2 no scan before third tick", busy, 0);
    chk("R2 time held", cur_time, 0);
    pulse_tick();
    chk("R2 scan starts on third tick", busy, 1);
    chk("R2 time increments", cur_time, 1);
    wait_done();
    chk_got("R4 R6 scan1", '{64, 72});
    rd(67, v); chk("R5 deadline cleared", v, 0);
    rd(65, v); chk("R5 wait bit cleared, others kept", v, 16'hF1);
    rd(75, v); chk("R5 second deadline cleared", v, 0);
    rd(73, v); chk("R5 second flags", v, 0);
    rd(69, v); chk("R4 zero deadline untouched", v, 2);

    @(negedge clk); wait_in = 0;      #1 chk("R9 forever", deadline, 0);
    @(negedge clk); wait_in = 5;      #1 chk("R9 sum", deadline, 6);
    @(negedge clk); wait_in = 16'hFFFF; #1 chk("R9 wrap to one", deadline, 1);
    @(negedge clk); wait_in = 16'hFFFE; #1 chk("R9 top value", deadline, 16'hFFFF);

    wr(71, 2); wr(67, 3); wr(255, 2); wr(3, 2); wr(1, 200);
    auto_ack = 0;
    pulse_tick(); pulse_tick(); pulse_tick();
    chk("R2 second scan time", cur_time, 2);
    for (int n = 0; n < 100 && !rq_req; n++) @(negedge clk);
    chk("R6 request raised", rq_req, 1);
    chk("R6 first handle", rq_handle, 68);
    pulse_tick(); pulse_tick();
    wr(100, 16'h1234);
    chk("R6 request held", rq_req, 1);
    chk("R6 handle stable", rq_handle, 68);
    chk("R6 scan stalled", busy, 1);
    auto_ack = 1;
    wait_done();
    chk_got("R3 R6 clamped scan", '{68, 252});
    rd(100, v); chk("R10 write during scan ignored", v, 16'hABCD);
    rd(3, v);   chk("R3 word past table untouched", v, 2);
    rd(69, v);  chk("R5 flags of expired", v, 0);
    rd(67, v);  chk("R4 non-matching deadline kept", v, 3);

    pulse_tick();
    chk("R8 one latched tick only", busy, 0);
    chk("R8 time held", cur_time, 2);
    pulse_tick();
    chk("R8 scan after latched tick", busy, 1);
    chk("R8 time", cur_time, 3);
    wait_done();
    chk_got("R4 third scan", '{64});

    wr(1, 0);
    pulse_tick(); pulse_tick(); pulse_tick();
    chk("R3 empty scan time", cur_time, 4);
    wait_done();
    chk_got("R3 empty scan", '{});
    @(negedge clk); wait_in = 16'hFFFC; #1 chk("R9 wrap at time 4", deadline, 1);
    @(negedge clk); wait_in = 5;        #1 chk("R9 sum at time 4", deadline, 9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule